// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers a wide set of level-sensitive peripheral interrupt lines and turns them into one interrupt output per CPU. Every CPU owns a complete, separate bank of enable words. An input reaches a CPU only when software has set that input's bit in that CPU's bank. One input can go to one CPU, to both, or to neither, and each routing is chosen on its own. The block does no prioritising and queues nothing. A software handler reads every status word of its own bank to find out which enabled lines are high.

Inputs pass through a two-stage synchronizer. Each bank then masks the synchronized lines with its enable bits. The bank's output register holds the OR of the masked bits. Software reaches the banks through a plain single-cycle register port: a select, a write flag, a byte address and 32-bit data. Read data is registered. Each CPU bank has a 32-byte address window, and the windows sit back to back.

Top module: `intc_aggr`

## Requirements
- R1: `NUM_IN` takes one of 32, 64 or 128, and each bank holds NW = NUM_IN/32 enable words and NW status words. Enable word k sits at window byte offset 4k, and status word k sits at byte offset 4(NW+k). Bit n of word k belongs to input 32k+n.
- R2: The window of CPU c starts at byte address 0x20*c (address bit 5 selects the CPU, bits 4:2 select the word). An access changes or returns only that CPU's bank.
- R3: An input counts as asserted exactly while it is high. A status bit reads as the synchronized input ANDed with the same CPU's enable bit, and nothing is latched: the bit clears once the input drops.
- R4: Enable words are plain read/write registers. A write replaces the whole word, and a later read returns the written value.
- R5: A write to a status word has no effect on any enable word or on status.
- R6: `cpu_irq[c]` is the registered OR of all of CPU c's status bits, and it is unaffected by the other CPU's enables.
- R7: Reads of unused offsets within a window, or of a window with no CPU behind it, return zero. Writes to such offsets change nothing.
- R8: `cpu_irq` follows an enabled input change on the third rising edge after it. It follows an enable write on the first rising edge after the edge that performs the write.
- R9: Reset clears all enables, `cpu_irq` and `bus_rdata`.
- R10: `bus_rdata` is loaded on the rising edge that accepts a read (`bus_sel` high, `bus_we` low), and it holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_IN | Level interrupt inputs, high = asserted |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | NUM_CPU | Interrupt output, one per CPU |

## Verification
Read data is due on the first rising edge after a read is accepted, so the bench samples it on the following falling edge. A change on an enabled input reaches `cpu_irq` on the third rising edge. The bench checks that the output is still unchanged after the second edge and has changed after the third, both when the output rises and when it falls. An enable write moves `cpu_irq` one edge after the write edge, and the bench checks the value both right after the write and one edge later.

// File: rtl/intc_aggr_pkg.sv
package intc_aggr_pkg;
  localparam int WORD_W  = 32;
  localparam int SLOT_W  = 3;   // eight word slots per CPU window
  localparam int WIN_LSB = 5;   // 32-byte window per CPU
  localparam int ADDR_W  = 6;   // one CPU-select bit above the window
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/intc_aggr_sync.sv
module intc_aggr_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/intc_aggr_bank.sv
module intc_aggr_bank
  import intc_aggr_pkg::*;
#(
  parameter int NUM_IN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  slot_t             slot,
  input  word_t             wdata,
  input  logic [NUM_IN-1:0] src,
  output logic [NUM_IN-1:0] en_q,
  output word_t             rd_word,
  output logic              irq_q
);
  localparam int NW = NUM_IN / WORD_W;

  word_t             en_w [NW];
  logic [NUM_IN-1:0] stat;

  for (genvar k = 0; k < NW; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              en_w[k] <= '0;
      else if (wr_stb && slot == slot_t'(k))   en_w[k] <= wdata;
    end
    assign en_q[k*WORD_W +: WORD_W] = en_w[k];
  end

  assign stat = src & en_q;

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NW; k++) begin
      if (slot == slot_t'(k))      rd_word = en_w[k];
      if (slot == slot_t'(NW + k)) rd_word = stat[k*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |stat;
  end
endmodule

// File: rtl/intc_aggr.sv
module intc_aggr
  import intc_aggr_pkg::*;
#(
  parameter int NUM_IN  = 64,
  parameter int NUM_CPU = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IN-1:0]  irq_src,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CPU-1:0] cpu_irq
);
  if (NUM_IN != 32 && NUM_IN != 64 && NUM_IN != 128) begin : g_bad_in
    $error("intc_aggr: NUM_IN must be 32, 64 or 128");
  end
  if (NUM_CPU < 1 || NUM_CPU > 2) begin : g_bad_cpu
    $error("intc_aggr: NUM_CPU must be 1 or 2");
  end

  logic [NUM_IN-1:0]               sync_q;
  logic [NUM_CPU-1:0][NUM_IN-1:0]  en_all;
  word_t                           bank_rd [NUM_CPU];
  logic [NUM_CPU-1:0]              hit;
  slot_t                           slot;
  logic                            win_idx;
  word_t                           rd_next;
  logic [1:0]                      addr_lsb_unused;

  assign slot            = bus_addr[WIN_LSB-1:2];
  assign win_idx         = bus_addr[WIN_LSB];
  assign addr_lsb_unused = bus_addr[1:0];

  intc_aggr_sync #(.WIDTH(NUM_IN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_src),
    .q     (sync_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign hit[c] = (win_idx == 1'(c));
    intc_aggr_bank #(.NUM_IN(NUM_IN)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (bus_sel & bus_we & hit[c]),
      .slot    (slot),
      .wdata   (bus_wdata),
      .src     (sync_q),
      .en_q    (en_all[c]),
      .rd_word (bank_rd[c]),
      .irq_q   (cpu_irq[c])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (hit[c]) rd_next = bank_rd[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/intc_aggr_chk.sv
module intc_aggr_chk
  import intc_aggr_pkg::*;
#(
  parameter int NUM_IN  = 64,
  parameter int NUM_CPU = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_sel,
  input logic                           bus_we,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [31:0]                    bus_wdata,
  input logic [31:0]                    bus_rdata,
  input logic [NUM_CPU-1:0]             cpu_irq,
  input logic [NUM_IN-1:0]              sync_q,
  input logic [NUM_CPU-1:0][NUM_IN-1:0] en_all
);
  localparam int NW = NUM_IN / WORD_W;

  logic [SLOT_W-1:0] c_slot;
  int                c_win;
  assign c_slot = bus_addr[WIN_LSB-1:2];
  assign c_win  = int'(bus_addr[WIN_LSB]);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cpu_irq == '0 && bus_rdata == '0 && en_all == '0));

  // R5
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && int'(c_slot) >= NW) |=> $stable(en_all));

  // R7
  unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && (int'(c_slot) >= 2*NW || c_win >= NUM_CPU)) |=> bus_rdata == '0);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    // R6
    irq_follows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] == $past(|(sync_q & en_all[c])));
    for (genvar k = 0; k < NW; k++) begin : g_k
      // R4
      enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && c_win == c && int'(c_slot) == k)
        |=> en_all[c][k*WORD_W +: WORD_W] == $past(bus_wdata));
    end
  end
endmodule

bind intc_aggr intc_aggr_chk #(.NUM_IN(NUM_IN), .NUM_CPU(NUM_CPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cpu_irq   (cpu_irq),
  .sync_q    (sync_q),
  .en_all    (en_all)
);

// File: tb/intc_aggr_test.sv
module intc_aggr_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 64;

  typedef struct packed {
    logic [63:0] src;
    logic [63:0] e0;
    logic [63:0] e1;
    logic [1:0]  exp_irq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{64'h0, {64{1'b1}}, {64{1'b1}}, 2'b00},
    '{64'h1, 64'h1, 64'h0, 2'b01},
    '{64'h0000_0100_0000_0000, 64'h1, 64'h0000_0100_0000_0000, 2'b10},
    '{64'h8000_0000_8000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000, 2'b11},
    '{{64{1'b1}}, 64'h0, 64'h0, 2'b00},
    '{64'hA5A5_A5A5_A5A5_A5A5, 64'h5A5A_5A5A_5A5A_5A5A, 64'h0000_0001_0000_0000, 2'b10}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_src = '0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [1:0]    cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_aggr #(.NUM_IN(NI), .NUM_CPU(2)) uut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] r2;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 irq in reset", 64'(cpu_irq), 64'h0);
    check("R9 rdata in reset", 64'(bus_rdata), 64'h0);
    rst_n = 1'b1;
    edges(1);
    check("R9 irq after reset", 64'(cpu_irq), 64'h0);
    rd(6'h00, r); check("R9 cpu0 enable word0 cleared", 64'(r), 64'h0);
    rd(6'h24, r); check("R9 cpu1 enable word1 cleared", 64'(r), 64'h0);

    // R4: whole-word read/write
    wr(6'h04, 32'hDEAD_BEEF);
    rd(6'h04, r); check("R4 enable readback", 64'(r), 64'hDEAD_BEEF);
    rd(6'h24, r); check("R2 cpu1 window untouched", 64'(r), 64'h0);
    wr(6'h04, 32'h0);

    // R10: read data holds while idle
    rd(6'h00, r);
    wr(6'h00, 32'h0000_00FF);
    edges(4);
    check("R10 rdata holds without read", 64'(bus_rdata), 64'(r));

    // R5: status writes ignored
    irq_src = '1;
    edges(3);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h00, r); check("R5 enable after status write", 64'(r), 64'hFF);
    rd(6'h08, r); check("R5 status after status write", 64'(r), 64'hFF);
    rd(6'h0C, r); check("R5 status hi stays zero", 64'(r), 64'h0);

    // R7: unused offsets
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h10, r);  check("R7 unused offset 0x10 reads zero", 64'(r), 64'h0);
    rd(6'h3C, r2); check("R7 unused offset 0x3C reads zero", 64'(r2), 64'h0);
    rd(6'h00, r);  check("R7 no alias into enable", 64'(r), 64'hFF);
    irq_src = '0;
    wr(6'h00, 32'h0);
    edges(3);

    // R8 / R3: input timing and no latching
    wr(6'h00, 32'h0000_0008);
    @(negedge clk);
    irq_src[3] = 1'b1;
    edges(2); check("R8 irq not early on rise", 64'(cpu_irq), 64'h0);
    edges(1); check("R8 irq on third edge", 64'(cpu_irq), 64'h1);
    irq_src[3] = 1'b0;
    edges(2); check("R8 irq held two edges on fall", 64'(cpu_irq), 64'h1);
    edges(1); check("R3 irq clears when input drops", 64'(cpu_irq), 64'h0);
    rd(6'h08, r); check("R3 status clears when input drops", 64'(r), 64'h0);

    // R8: enable write latency
    irq_src[5] = 1'b1;
    edges(3); check("R8 disabled input no irq", 64'(cpu_irq), 64'h0);
    wr(6'h00, 32'h0000_0020);
    check("R8 irq not on write edge", 64'(cpu_irq), 64'h0);
    edges(1); check("R8 irq one edge after enable write", 64'(cpu_irq), 64'h1);
    wr(6'h00, 32'h0);
    check("R8 irq held on disable edge", 64'(cpu_irq), 64'h1);
    edges(1); check("R6 irq drops after disable", 64'(cpu_irq), 64'h0);
    irq_src = '0;

    // Vector table: routing, masking, bit mapping
    for (int i = 0; i < 6; i++) begin
      wr(6'h00, VECS[i].e0[31:0]);
      wr(6'h04, VECS[i].e0[63:32]);
      wr(6'h20, VECS[i].e1[31:0]);
      wr(6'h24, VECS[i].e1[63:32]);
      @(negedge clk);
      irq_src = VECS[i].src;
      edges(3);
      check($sformatf("R6 vector %0d irq", i), 64'(cpu_irq), 64'(VECS[i].exp_irq));
      rd(6'h08, r); check($sformatf("R3 vector %0d cpu0 status lo", i), 64'(r), 64'((VECS[i].src & VECS[i].e0) & 64'hFFFF_FFFF));
      rd(6'h0C, r); check($sformatf("R1 vector %0d cpu0 status hi", i), 64'(r), (VECS[i].src & VECS[i].e0) >> 32);
      rd(6'h28, r); check($sformatf("R2 vector %0d cpu1 status lo", i), 64'(r), 64'((VECS[i].src & VECS[i].e1) & 64'hFFFF_FFFF));
      rd(6'h2C, r); check($sformatf("R1 vector %0d cpu1 status hi", i), 64'(r), (VECS[i].src & VECS[i].e1) >> 32);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule